// File: doc/BRIEF.md
# Sampled Phase-Frequency Detector with Selectable Output Sense

This block compares two divided clock-like signals that have already been brought into the system clock domain: a divided reference (`fr_div`) and a divided oscillator feedback (`fp_div`). A small state machine records which of the two produced a rising edge first. It turns that order into pump commands and into a pair of comparator levels meant for an external pump stage. After both edges have arrived, a clear interval of a fixed number of cycles follows. An in-phase pair therefore leaves the pump undriven. The output sense is set by `pol_sel`, so the same block can serve loops whose oscillator tunes in either direction.

Each pump output is modelled digitally as three wires: drive-up, drive-down and output-enable. A high-impedance pump shows all three low. The first pump follows the detector at all times. The second pump follows it only while `latch_en` is high. Asserting `pwr_save` releases both pumps and holds the detector idle. A monitor output, `mon_out`, carries one of the two divided inputs, selected by `pol_sel`.

The state machine has four states. IDLE waits for edges. LEAD means a reference edge was seen first. LAG means a feedback edge was seen first. CLEAR is the hold interval after both edges. The transitions are as follows:
- IDLE to LEAD on a reference-only rise.
- IDLE to LAG on a feedback-only rise.
- IDLE to CLEAR on a simultaneous rise.
- LEAD to CLEAR on a feedback rise.
- LAG to CLEAR on a reference rise.
- CLEAR to IDLE after `CLR_CYC` cycles.
- Any state to IDLE while power save is asserted.

Top module: `pfd_polarity_top`

## Requirements
- R1: During and right after reset the detector is IDLE. Both pumps are high impedance, `xcp_a` is 0 and `xcp_b` is 1.
- R2: With `pol_sel`=1, a reference rise seen first makes pump 1 drive up from the next cycle, with `xcp_a`=0 and `xcp_b`=0. This lasts until the feedback rise arrives.
- R3: With `pol_sel`=1, a feedback rise seen first makes pump 1 drive down, with `xcp_a`=1 and `xcp_b`=1.
- R4: With `pol_sel`=0 the sense is reversed. A leading reference gives drive down with `xcp_a`=1 and `xcp_b`=1. A lagging reference gives drive up with `xcp_a`=0 and `xcp_b`=0.
- R5: Once the second edge arrives, the detector enters CLEAR and shows the neutral pattern (pumps Z, `xcp_a`=0, `xcp_b`=1) for `CLR_CYC` (default 3) samples. It is IDLE at the sample after that. Rising edges that arrive during CLEAR are ignored.
- R6: If both inputs rise in the same cycle, the detector goes directly to CLEAR and the pump is never driven.
- R7: `mon_out` equals `fr_div` when `pol_sel`=1 and `fp_div` when `pol_sel`=0.
- R8: Pump 2 repeats pump 1 while `latch_en`=1. While `latch_en`=0 it is high impedance, with all three wires low.
- R9: While `pwr_save`=1, both pumps are high impedance and the detector is forced to IDLE. Rising edges seen during power save are discarded, and the detector is still IDLE after power save is released.
- R10: A repeated rise of the leading input while the detector is waiting for the other input leaves the state unchanged.
- R11: A pump never drives up and down together, and its enable is high exactly when one drive direction is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fr_div | input | 1 | Divided reference, synchronous to clk |
| fp_div | input | 1 | Divided oscillator feedback, synchronous to clk |
| pol_sel | input | 1 | Output sense: 1 normal, 0 reversed |
| latch_en | input | 1 | Enable for pump 2 |
| pwr_save | input | 1 | Power save, active high |
| pump1_up | output | 1 | Pump 1 drive up |
| pump1_dn | output | 1 | Pump 1 drive down |
| pump1_oe | output | 1 | Pump 1 output enable (0 = high impedance) |
| pump2_up | output | 1 | Pump 2 drive up |
| pump2_dn | output | 1 | Pump 2 drive down |
| pump2_oe | output | 1 | Pump 2 output enable (0 = high impedance) |
| xcp_a | output | 1 | Comparator level A for an external pump |
| xcp_b | output | 1 | Comparator level B for an external pump |
| mon_out | output | 1 | Monitor of the selected divided input |

## Verification
Two functions can collide in one cycle, and both collisions are provoked on purpose. In the first, both divided inputs rise on the same clock edge. The bench then expects the neutral pattern on the very next sample, with no cycle of pump drive, followed by exactly `CLR_CYC` neutral samples. In the second, power save is raised while the detector is in LEAD, and a feedback edge is delivered during the power save. The bench judges this case by requiring high impedance immediately and a plain IDLE pattern after release. If the edge had been taken, the pump would show drive down.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_LAG   = 2'd2,
        ST_CLEAR = 2'd3
    } pfd_state_t;

    typedef struct packed {
        logic up;
        logic dn;
        logic oe;
    } pump_drv_t;

    localparam int N_INPUTS = 2;
    localparam int IDX_REF  = 0;
    localparam int IDX_FB   = 1;
    localparam int N_PUMPS  = 2;

endpackage

// File: rtl/pfd_rise_det.sv
module pfd_rise_det #(
    parameter int N_CH = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] sig_in,
    output logic [N_CH-1:0] rise_o
);

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
        logic prev_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prev_q <= 1'b0;
            end else begin
                prev_q <= sig_in[ch];
            end
        end

        assign rise_o[ch] = sig_in[ch] & ~prev_q;
    end

endmodule

// File: rtl/pfd_seq.sv
module pfd_seq
    import pfd_pkg::*;
#(
    parameter int CLR_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_rise,
    input  logic fb_rise,
    input  logic hold_idle,
    output logic lead_o,
    output logic lag_o
);

    localparam int CW = (CLR_CYC > 1) ? $clog2(CLR_CYC) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(CLR_CYC - 1);

    pfd_state_t       state_q;
    pfd_state_t       state_nx;
    logic [CW-1:0]    cnt_q;
    logic             clr_done;

    assign clr_done = (cnt_q == CNT_LAST);

    // state register and clear-interval counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_nx;
            if (state_q != ST_CLEAR) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // next state
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ref_rise && fb_rise) begin
                    state_nx = ST_CLEAR;
                end else if (ref_rise) begin
                    state_nx = ST_LEAD;
                end else if (fb_rise) begin
                    state_nx = ST_LAG;
                end
            end
            ST_LEAD: begin
                if (fb_rise) begin
                    state_nx = ST_CLEAR;
                end
            end
            ST_LAG: begin
                if (ref_rise) begin
                    state_nx = ST_CLEAR;
                end
            end
            ST_CLEAR: begin
                if (clr_done) begin
                    state_nx = ST_IDLE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
        if (hold_idle) begin
            state_nx = ST_IDLE;
        end
    end

    // outputs
    always_comb begin
        lead_o = 1'b0;
        lag_o  = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_LEAD:  lead_o = 1'b1;
            ST_LAG:   lag_o  = 1'b1;
            ST_CLEAR: ;
            default:  ;
        endcase
    end

endmodule

// File: rtl/pfd_drive_map.sv
module pfd_drive_map
    import pfd_pkg::*;
(
    input  logic      lead,
    input  logic      lag,
    input  logic      pol_sel,
    input  logic      latch_en,
    input  logic      pwr_save,
    output pump_drv_t pump_o [N_PUMPS],
    output logic      xcp_a,
    output logic      xcp_b
);

    logic drv_up;
    logic drv_dn;
    logic [N_PUMPS-1:0] gate;

    assign drv_up = pol_sel ? lead : lag;
    assign drv_dn = pol_sel ? lag  : lead;

    assign xcp_a = drv_dn;
    assign xcp_b = ~drv_up;

    assign gate[0] = 1'b1;
    assign gate[1] = latch_en;

    for (genvar k = 0; k < N_PUMPS; k++) begin : g_pump
        logic act;
        assign act          = gate[k] & ~pwr_save;
        assign pump_o[k].up = drv_up & act;
        assign pump_o[k].dn = drv_dn & act;
        assign pump_o[k].oe = (drv_up | drv_dn) & act;
    end

endmodule

// File: rtl/pfd_polarity_top.sv
module pfd_polarity_top
    import pfd_pkg::*;
#(
    parameter int CLR_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fr_div,
    input  logic fp_div,
    input  logic pol_sel,
    input  logic latch_en,
    input  logic pwr_save,
    output logic pump1_up,
    output logic pump1_dn,
    output logic pump1_oe,
    output logic pump2_up,
    output logic pump2_dn,
    output logic pump2_oe,
    output logic xcp_a,
    output logic xcp_b,
    output logic mon_out
);

    logic [N_INPUTS-1:0] sig_vec;
    logic [N_INPUTS-1:0] rise_vec;
    logic                lead;
    logic                lag;
    pump_drv_t           pumps [N_PUMPS];

    assign sig_vec[IDX_REF] = fr_div;
    assign sig_vec[IDX_FB]  = fp_div;

    pfd_rise_det #(.N_CH(N_INPUTS)) u_rise (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_in (sig_vec),
        .rise_o (rise_vec)
    );

    pfd_seq #(.CLR_CYC(CLR_CYC)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_rise  (rise_vec[IDX_REF]),
        .fb_rise   (rise_vec[IDX_FB]),
        .hold_idle (pwr_save),
        .lead_o    (lead),
        .lag_o     (lag)
    );

    pfd_drive_map u_map (
        .lead     (lead),
        .lag      (lag),
        .pol_sel  (pol_sel),
        .latch_en (latch_en),
        .pwr_save (pwr_save),
        .pump_o   (pumps),
        .xcp_a    (xcp_a),
        .xcp_b    (xcp_b)
    );

    assign pump1_up = pumps[0].up;
    assign pump1_dn = pumps[0].dn;
    assign pump1_oe = pumps[0].oe;
    assign pump2_up = pumps[1].up;
    assign pump2_dn = pumps[1].dn;
    assign pump2_oe = pumps[1].oe;

    assign mon_out = pol_sel ? fr_div : fp_div;

endmodule

// File: rtl/pfd_polarity_chk.sv
module pfd_polarity_chk (
    input logic clk,
    input logic rst_n,
    input logic fr_div,
    input logic fp_div,
    input logic pol_sel,
    input logic latch_en,
    input logic pwr_save,
    input logic pump1_up,
    input logic pump1_dn,
    input logic pump1_oe,
    input logic pump2_up,
    input logic pump2_dn,
    input logic pump2_oe,
    input logic xcp_a,
    input logic xcp_b,
    input logic mon_out
);

    assert_no_contention_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(pump1_up && pump1_dn) && (pump1_oe == (pump1_up || pump1_dn)));

    assert_sleep_hiz_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_save |-> (!pump1_oe && !pump2_oe));

    assert_pump2_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_en |-> (!pump2_oe && !pump2_up && !pump2_dn));

    assert_pump2_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_en && !pwr_save) |-> (pump2_up == pump1_up && pump2_dn == pump1_dn));

    assert_mon_sel_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mon_out == (pol_sel ? fr_div : fp_div));

    assert_neutral_levels_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!pump1_oe && !pwr_save) |-> (!xcp_a && xcp_b));

    assert_up_levels_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pump1_up |-> (!xcp_a && !xcp_b));

    assert_dn_levels_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pump1_dn |-> (xcp_a && xcp_b));

endmodule

bind pfd_polarity_top pfd_polarity_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .fr_div   (fr_div),
    .fp_div   (fp_div),
    .pol_sel  (pol_sel),
    .latch_en (latch_en),
    .pwr_save (pwr_save),
    .pump1_up (pump1_up),
    .pump1_dn (pump1_dn),
    .pump1_oe (pump1_oe),
    .pump2_up (pump2_up),
    .pump2_dn (pump2_dn),
    .pump2_oe (pump2_oe),
    .xcp_a    (xcp_a),
    .xcp_b    (xcp_b),
    .mon_out  (mon_out)
);

// File: tb/pfd_polarity_top_tb_top.sv
module pfd_polarity_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int PZ = 0;
    localparam int PU = 1;
    localparam int PD = 2;

    typedef struct {
        int    p1;
        int    p2;
        logic  a;
        logic  b;
        logic  mon;
        string req;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fr_div = 1'b0;
    logic fp_div = 1'b0;
    logic pol_sel = 1'b1;
    logic latch_en = 1'b1;
    logic pwr_save = 1'b0;
    logic pump1_up, pump1_dn, pump1_oe;
    logic pump2_up, pump2_dn, pump2_oe;
    logic xcp_a, xcp_b, mon_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pfd_polarity_top dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .fr_div   (fr_div),
        .fp_div   (fp_div),
        .pol_sel  (pol_sel),
        .latch_en (latch_en),
        .pwr_save (pwr_save),
        .pump1_up (pump1_up),
        .pump1_dn (pump1_dn),
        .pump1_oe (pump1_oe),
        .pump2_up (pump2_up),
        .pump2_dn (pump2_dn),
        .pump2_oe (pump2_oe),
        .xcp_a    (xcp_a),
        .xcp_b    (xcp_b),
        .mon_out  (mon_out)
    );

    function automatic int pcode(input logic up, input logic dn, input logic oe);
        if (!oe && !up && !dn) return PZ;
        if (oe && up && !dn)   return PU;
        if (oe && dn && !up)   return PD;
        return 3;
    endfunction

    // driver: apply one cycle of stimulus, queue what the next sample must show
    task automatic step(input logic fr, input logic fp, input logic fc,
                        input logic lat, input logic slp,
                        input int e1, input int e2, input logic ea, input logic eb,
                        input string req);
        exp_t it;
        @(negedge clk);
        fr_div   = fr;
        fp_div   = fp;
        pol_sel  = fc;
        latch_en = lat;
        pwr_save = slp;
        it.p1  = e1;
        it.p2  = e2;
        it.a   = ea;
        it.b   = eb;
        it.mon = fc ? fr : fp;
        it.req = req;
        exp_q.push_back(it);
    endtask

    task automatic neutral(input int n, input logic fc, input string req);
        for (int i = 0; i < n; i++) begin
            step(1'b0, 1'b0, fc, 1'b1, 1'b0, PZ, PZ, 1'b0, 1'b1, req);
        end
    endtask

    // monitor: compare away from the active edge
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (exp_q.size() > 0) begin
                exp_t it;
                int a1;
                int a2;
                it = exp_q.pop_front();
                a1 = pcode(pump1_up, pump1_dn, pump1_oe);
                a2 = pcode(pump2_up, pump2_dn, pump2_oe);
                checks++;
                if (a1 != it.p1 || a2 != it.p2 || xcp_a !== it.a ||
                    xcp_b !== it.b || mon_out !== it.mon) begin
                    errors++;
                    $display("FAIL %s: got p1=%0d p2=%0d a=%b b=%b mon=%b, expected p1=%0d p2=%0d a=%b b=%b mon=%b",
                             it.req, a1, a2, xcp_a, xcp_b, mon_out,
                             it.p1, it.p2, it.a, it.b, it.mon);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        #(CLK_PERIOD * 2 + 2);
        checks++;
        if (pcode(pump1_up, pump1_dn, pump1_oe) != PZ ||
            pcode(pump2_up, pump2_dn, pump2_oe) != PZ || xcp_a !== 1'b0 || xcp_b !== 1'b1) begin
            errors++;
            $display("FAIL R1: got oe1=%b oe2=%b a=%b b=%b, expected 0 0 0 1",
                     pump1_oe, pump2_oe, xcp_a, xcp_b);
        end
        @(negedge clk);
        rst_n = 1'b1;
        neutral(1, 1'b1, "R1");

        // R2 lead with normal sense, R10 repeated reference rise
        step(1, 0, 1, 1, 0, PU, PU, 0, 0, "R2");
        step(1, 0, 1, 1, 0, PU, PU, 0, 0, "R2");
        step(0, 0, 1, 1, 0, PU, PU, 0, 0, "R2");
        step(1, 0, 1, 1, 0, PU, PU, 0, 0, "R10");
        // R5 clear interval, edge inside it ignored
        step(1, 1, 1, 1, 0, PZ, PZ, 0, 1, "R5");
        step(0, 0, 1, 1, 0, PZ, PZ, 0, 1, "R5");
        step(0, 1, 1, 1, 0, PZ, PZ, 0, 1, "R5");
        step(0, 1, 1, 1, 0, PZ, PZ, 0, 1, "R5");
        step(0, 0, 1, 1, 0, PZ, PZ, 0, 1, "R5");

        // R3 lag with normal sense
        step(0, 1, 1, 1, 0, PD, PD, 1, 1, "R3");
        step(0, 1, 1, 1, 0, PD, PD, 1, 1, "R3");
        step(1, 1, 1, 1, 0, PZ, PZ, 0, 1, "R5");
        neutral(3, 1'b1, "R5");

        // R4 reversed sense, R7 monitor follows fp
        step(1, 0, 0, 1, 0, PD, PD, 1, 1, "R4");
        step(1, 1, 0, 1, 0, PZ, PZ, 0, 1, "R7");
        neutral(3, 1'b0, "R5");
        step(0, 1, 0, 1, 0, PU, PU, 0, 0, "R4");
        step(1, 1, 0, 1, 0, PZ, PZ, 0, 1, "R7");
        neutral(3, 1'b0, "R5");

        // R6 simultaneous rise: never driven, exactly three neutral samples of clear
        step(1, 1, 1, 1, 0, PZ, PZ, 0, 1, "R6");
        step(1, 1, 1, 1, 0, PZ, PZ, 0, 1, "R6");
        step(1, 1, 1, 1, 0, PZ, PZ, 0, 1, "R6");
        step(0, 0, 1, 1, 0, PZ, PZ, 0, 1, "R6");
        // idle must now accept a fresh lead right away
        step(1, 0, 1, 1, 0, PU, PU, 0, 0, "R6");
        step(1, 1, 1, 1, 0, PZ, PZ, 0, 1, "R5");
        neutral(3, 1'b1, "R5");

        // R8 pump 2 gating
        step(1, 0, 1, 0, 0, PU, PZ, 0, 0, "R8");
        step(1, 0, 1, 1, 0, PU, PU, 0, 0, "R8");
        step(0, 0, 1, 0, 0, PU, PZ, 0, 0, "R8");
        step(0, 1, 1, 1, 0, PZ, PZ, 0, 1, "R8");
        neutral(3, 1'b1, "R5");

        // R9 power save during LEAD, feedback edge while asleep is dropped
        step(1, 0, 1, 1, 0, PU, PU, 0, 0, "R9");
        step(1, 0, 1, 1, 1, PZ, PZ, 0, 1, "R9");
        step(1, 1, 1, 1, 1, PZ, PZ, 0, 1, "R9");
        step(1, 1, 1, 1, 0, PZ, PZ, 0, 1, "R9");
        step(0, 0, 1, 1, 0, PZ, PZ, 0, 1, "R9");
        step(0, 1, 1, 1, 0, PD, PD, 1, 1, "R9");
        step(1, 1, 1, 1, 0, PZ, PZ, 0, 1, "R5");
        neutral(3, 1'b1, "R5");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule